// File: doc/BRIEF.md
# NAND Ready and Status Waiter

This block takes over from the command sequencer once a program, erase or reset operation has been issued to a NAND flash part. It waits for the part to finish, then returns one status byte to the sequencer. The mode is fixed at start time. If the board wires the ready/busy line, the block watches that line. Otherwise it reads the status byte over the bus again and again and tests its ready bit. Either way, it first keeps a short write-to-busy hold-off. It then sends a single STATUS opcode so that the part drives status on reads.

Wait limits are counted in milliseconds by a prescaled tick, so a simulation can shrink them by overriding the cycles-per-millisecond parameter. After polling stops, the block reads the status byte one last time. It keeps that byte and pulses `done`. Two flags go with the byte. One flag says the limit expired. The other says the final byte still showed busy. Reset completion on a part without a ready line waits a longer fixed chip delay before polling and uses a shorter limit.

Top module: `nand_ready_waiter`

## Requirements
- R1: After reset, `busy`, `done`, `timed_out`, `inconsistent` and `status` are all zero. While idle, `rd_req` and `wr_valid` stay low.
- R2: For a program/erase wait, and for a reset wait with the ready line present, `wr_valid` first rises TWB_CYC cycles after the cycle in which `start` is accepted. TWB_CYC is the tWB time (100 ns by default) rounded up to clock cycles.
- R3: Before any polling, exactly one command write is made. It carries opcode 70h in `wr_data[7:0]`, has `wr_data[15:8]` at zero and has `wr_cle` high. The write completes when `wr_valid` and `wr_ready` are both high.
- R4: With `rb_present` high at start, completion follows `rb_ready`. No status read is made during the wait, so exactly one read (the final one) occurs per operation.
- R5: With `rb_present` low, reads are repeated until a returned byte has bit 6 (mask 40h, ready) set.
- R6: If the part is still not ready when OP_MS milliseconds (400 by default) have elapsed, the wait ends and `timed_out` is set.
- R7: The byte from the final read appears on `status` unchanged, including bit 0 (pass/fail). `inconsistent` is set exactly when bit 6 of that byte is clear.
- R8: A reset wait with `rb_present` low holds off CHIP_DELAY_US microseconds before its command write and uses a limit of RST_MS milliseconds (250 by default).
- R9: `done` is a one-cycle pulse in the cycle after the final read handshake. `busy` is high from the cycle after `start` until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a wait (accepted while idle) |
| op_is_reset | input | 1 | 1: reset completion, 0: program/erase completion |
| rb_present | input | 1 | 1: ready/busy line is wired |
| rb_ready | input | 1 | Ready/busy line, 1 = ready |
| wr_valid | output | 1 | Command write request |
| wr_ready | input | 1 | Bus accepts the command write |
| wr_data | output | 16 | Command word; upper byte zero |
| wr_cle | output | 1 | Command latch flag for the write |
| rd_req | output | 1 | Status byte read request |
| rd_valid | input | 1 | Read data returned (handshake with rd_req) |
| rd_data | input | 8 | Status byte from the part |
| busy | output | 1 | Wait in progress |
| done | output | 1 | Completion pulse |
| status | output | 8 | Final status byte |
| timed_out | output | 1 | Limit expired before ready |
| inconsistent | output | 1 | Final status byte not ready |

## Verification
The command write falls due a fixed number of cycles after the start edge. That number is tWB for most waits and the chip delay for a reset without the ready line. The bench counts cycles from the start edge and expects the first `wr_valid` one sample after that count. `done` is due one cycle after the final read handshake. The bench samples it at the falling edge after that handshake and expects it low again one cycle later. A timeout is due OP_MS or RST_MS tick periods after start. The bench accepts completion only inside a small window past that count, which covers the final read latency of its bus model.

// File: rtl/nand_ready_waiter.sv
module nand_ready_waiter #(
  parameter int CLK_MHZ       = 100,
  parameter int TWB_NS        = 100,
  parameter int CHIP_DELAY_US = 20,
  parameter int MS_CYC        = CLK_MHZ * 1000,
  parameter int OP_MS         = 400,
  parameter int RST_MS        = 250,
  parameter int RDY_BIT       = 6,
  parameter logic [7:0] STATUS_OP = 8'h70
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        op_is_reset,
  input  logic        rb_present,
  input  logic        rb_ready,
  output logic        wr_valid,
  input  logic        wr_ready,
  output logic [15:0] wr_data,
  output logic        wr_cle,
  output logic        rd_req,
  input  logic        rd_valid,
  input  logic [7:0]  rd_data,
  output logic        busy,
  output logic        done,
  output logic [7:0]  status,
  output logic        timed_out,
  output logic        inconsistent
);
  localparam int TWB_RAW  = (TWB_NS * CLK_MHZ + 999) / 1000;
  localparam int TWB_CYC  = (TWB_RAW < 1) ? 1 : TWB_RAW;
  localparam int CHIP_RAW = CHIP_DELAY_US * CLK_MHZ;
  localparam int CHIP_CYC = (CHIP_RAW < TWB_CYC) ? TWB_CYC : CHIP_RAW;
  localparam int HW       = $clog2(CHIP_CYC + 1);
  localparam int PW       = $clog2(MS_CYC + 1);
  localparam int MS_MAX   = (OP_MS > RST_MS) ? OP_MS : RST_MS;
  localparam int MW       = $clog2(MS_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_HOLD, S_CMD, S_POLL, S_FINAL} st_t;

  st_t            st;
  logic           kind_rst, pin_mode;
  logic [HW-1:0]  hold_cnt;
  logic [PW-1:0]  pre_cnt;
  logic [MW-1:0]  ms_cnt;

  wire long_path = kind_rst && !pin_mode;
  wire [HW-1:0] hold_last = long_path ? HW'(CHIP_CYC - 1) : HW'(TWB_CYC - 1);
  wire [MW-1:0] ms_limit  = long_path ? MW'(RST_MS) : MW'(OP_MS);
  wire rd_hs      = rd_req && rd_valid;
  wire ready_seen = pin_mode ? rb_ready : (rd_hs && rd_data[RDY_BIT]);

  assign busy     = (st != S_IDLE);
  assign wr_valid = (st == S_CMD);
  assign wr_cle   = (st == S_CMD);
  assign wr_data  = {8'h00, STATUS_OP};
  assign rd_req   = (st == S_FINAL) || (st == S_POLL && !pin_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      kind_rst     <= 1'b0;
      pin_mode     <= 1'b0;
      hold_cnt     <= '0;
      done         <= 1'b0;
      status       <= '0;
      timed_out    <= 1'b0;
      inconsistent <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          kind_rst     <= op_is_reset;
          pin_mode     <= rb_present;
          hold_cnt     <= '0;
          timed_out    <= 1'b0;
          inconsistent <= 1'b0;
          st           <= S_HOLD;
        end
        S_HOLD: begin
          if (hold_cnt == hold_last) st <= S_CMD;
          else hold_cnt <= hold_cnt + 1'b1;
        end
        S_CMD: if (wr_ready) st <= S_POLL;
        S_POLL: begin
          if (ready_seen) st <= S_FINAL;
          else if (ms_cnt >= ms_limit) begin
            timed_out <= 1'b1;
            st        <= S_FINAL;
          end
        end
        S_FINAL: if (rd_hs) begin
          status       <= rd_data;
          inconsistent <= !rd_data[RDY_BIT];
          done         <= 1'b1;
          st           <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || st == S_IDLE) begin
      pre_cnt <= '0;
      ms_cnt  <= '0;
    end else if (pre_cnt == PW'(MS_CYC - 1)) begin
      pre_cnt <= '0;
      if (ms_cnt != MW'(MS_MAX)) ms_cnt <= ms_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/nand_ready_waiter_chk.sv
module nand_ready_waiter_chk #(
  parameter int CLK_MHZ = 100,
  parameter int TWB_NS  = 100,
  parameter int RDY_BIT = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [7:0]  status,
  input logic        inconsistent,
  input logic        wr_valid,
  input logic [15:0] wr_data,
  input logic        wr_cle,
  input logic        rd_req
);
  localparam int TWB_RAW = (TWB_NS * CLK_MHZ + 999) / 1000;
  localparam int TWB_CYC = (TWB_RAW < 1) ? 1 : TWB_RAW;

  logic [15:0] since;
  always_ff @(posedge clk) begin
    if (!rst_n) since <= '0;
    else if (start && !busy) since <= 16'd1;
    else if (since != 16'hFFFF) since <= since + 1'b1;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req && !wr_valid));
  a_r3_cmd_word: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_cle && wr_data == 16'h0070));
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && rd_req));
  a_r2_twb_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> (since >= 16'(TWB_CYC + 1)));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r7_incons_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (inconsistent == !status[RDY_BIT]));
endmodule

bind nand_ready_waiter nand_ready_waiter_chk #(
  .CLK_MHZ(CLK_MHZ), .TWB_NS(TWB_NS), .RDY_BIT(RDY_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .status(status), .inconsistent(inconsistent), .wr_valid(wr_valid),
  .wr_data(wr_data), .wr_cle(wr_cle), .rd_req(rd_req)
);

// File: tb/nand_ready_waiter_tb.sv
module nand_ready_waiter_tb;
  localparam int CLK_PERIOD = 20;
  localparam int CLK_MHZ  = 50;
  localparam int MS_CYC   = 8;
  localparam int OP_MS    = 400;
  localparam int RST_MS   = 250;
  localparam int TWB_CYC  = 5;
  localparam int CHIP_CYC = 1000;
  localparam int NEVER    = 1000000;

  logic clk = 0, rst_n = 0, start = 0, op_is_reset = 0, rb_present = 0, rb_ready = 0;
  logic wr_valid, wr_ready = 0, wr_cle, rd_req, rd_valid = 0;
  logic [15:0] wr_data;
  logic [7:0] rd_data = 0, status;
  logic busy, done, timed_out, inconsistent;

  nand_ready_waiter #(.CLK_MHZ(CLK_MHZ), .MS_CYC(MS_CYC), .OP_MS(OP_MS), .RST_MS(RST_MS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_is_reset(op_is_reset),
    .rb_present(rb_present), .rb_ready(rb_ready), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .wr_cle(wr_cle), .rd_req(rd_req),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done),
    .status(status), .timed_out(timed_out), .inconsistent(inconsistent));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int gcyc = 0, t0 = 0, ready_at = NEVER;
  bit liar = 0;
  int nreads = 0, ncmds = 0, first_wr = -1, wait_cnt = 0, lat = 1;
  logic [7:0] last_byte = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit dev_ready();
    return (gcyc - t0) >= ready_at;
  endfunction

  function automatic logic [7:0] mk_byte(input bit rdy);
    logic [7:0] b;
    b = 8'($urandom);
    b[6] = rdy;
    return b;
  endfunction

  always @(posedge clk) gcyc <= gcyc + 1;

  always @(negedge clk) begin
    rb_ready = dev_ready();
    rd_valid = 0;
    if (rd_req) begin
      if (wait_cnt >= lat) begin
        rd_valid = 1;
        rd_data = mk_byte(dev_ready() && !liar);
        last_byte = rd_data;
        nreads++;
        wait_cnt = 0;
        lat = 1 + int'($urandom % 3);
      end else wait_cnt++;
    end
    wr_ready = ($urandom % 3) != 0;
    if (wr_valid && first_wr < 0) first_wr = gcyc - t0;
    if (wr_valid && wr_ready) begin
      ncmds++;
      if (wr_data != 16'h0070 || !wr_cle)
        chk(0, "R3 command word", int'(wr_data), 32'h70);
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <150000", wd);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic run_op(input bit is_rst, input bit pin, input int rdy_at, input bit lie,
                        output int dt);
    @(posedge clk); #2;
    op_is_reset = is_rst; rb_present = pin; ready_at = rdy_at; liar = lie;
    nreads = 0; ncmds = 0; first_wr = -1; wait_cnt = 0;
    t0 = gcyc; start = 1;
    @(posedge clk); #2; start = 0;
    dt = 0;
    do begin @(negedge clk); dt = gcyc - t0; end while (!done && dt < 20000);
  endtask

  task automatic check_common(input bit is_rst, input bit pin, input int dt,
                              input bit exp_to, input string tag);
    int hold;
    hold = (is_rst && !pin) ? CHIP_CYC : TWB_CYC;
    chk(done, {tag, " R9 done"}, done, 1);
    chk(first_wr == hold + 1, {tag, (is_rst && !pin) ? " R8 chip delay" : " R2 tWB"}, first_wr, hold + 1);
    chk(ncmds == 1, {tag, " R3 one STATUS write"}, ncmds, 1);
    chk(status == last_byte, {tag, " R7 status byte"}, status, last_byte);
    chk(inconsistent == !last_byte[6], {tag, " R7 inconsistent"}, inconsistent, !last_byte[6]);
    chk(timed_out == exp_to, {tag, " R6 timed_out"}, timed_out, exp_to);
    if (pin) chk(nreads == 1, {tag, " R4 single read"}, nreads, 1);
    @(negedge clk);
    chk(!done && !busy, {tag, " R9 done pulse"}, done, 0);
  endtask

  initial begin
    int dt, lim;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !timed_out && !inconsistent && status == 0 && !rd_req && !wr_valid,
        "R1 reset state", {busy, done, rd_req, wr_valid}, 0);
    @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);

    run_op(0, 1, 40, 0, dt); check_common(0, 1, dt, 0, "dir pin");
    run_op(0, 0, 60, 0, dt); check_common(0, 0, dt, 0, "dir poll");
    chk(nreads > 2 && last_byte[6], "R5 repeated polls", nreads, 3);

    run_op(0, 1, 30, 1, dt); check_common(0, 1, dt, 0, "dir liar");
    chk(inconsistent == 1, "R7 liar flagged", inconsistent, 1);

    run_op(0, 0, NEVER, 0, dt); check_common(0, 0, dt, 1, "dir op timeout");
    lim = OP_MS * MS_CYC;
    chk(dt >= lim && dt <= lim + 16, "R6 400ms window", dt, lim);
    chk(inconsistent == 1, "R6 busy final", inconsistent, 1);

    run_op(1, 0, NEVER, 0, dt); check_common(1, 0, dt, 1, "dir rst timeout");
    lim = RST_MS * MS_CYC;
    chk(dt >= lim && dt <= lim + 16, "R8 250ms window", dt, lim);

    run_op(1, 1, NEVER, 0, dt); check_common(1, 1, dt, 1, "dir rst pin timeout");
    lim = OP_MS * MS_CYC;
    chk(dt >= lim && dt <= lim + 16, "R6 pin window", dt, lim);

    for (int i = 0; i < 12; i++) begin
      bit k, p;
      int ra;
      k = 1'($urandom); p = 1'($urandom);
      ra = 10 + int'($urandom % 300);
      if (k && !p) ra = ra + CHIP_CYC;
      run_op(k, p, ra, 0, dt);
      check_common(k, p, dt, 0, "rand");
      chk(!inconsistent && status[6], "rand R5 ready", status, 8'h40);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule